// File: doc/BRIEF.md
# Multirate Row Refresh Scheduler

This block decides which DRAM rows receive a refresh command and issues those commands one at a time to a DRAM model. Time is divided into normal refresh windows, each a fixed number of base ticks long. In every window the scheduler walks the whole row space once, in ascending order, and makes one decision per row. A one-bit rate entry per row selects the rate. A row marked fast is refreshed in every window. A row marked slow is refreshed only in one window out of every `SLOW_MULT` windows, so its refresh period is that many times longer.

The rate table is filled from retention-profiling results through a bulk-load port while the scheduler is disabled. Once refresh is running, the only way to change the table is an upgrade request. An upgrade moves one row to the fast rate, for example after a corrected memory error in that row shows that its retention has become weak. Refresh commands leave the block over a valid/ready handshake that carries the row address.

Top module: `refresh_sched`

## Requirements
- R1: After reset, and while `en` is low before any window has begun, `ref_valid` stays low.
- R2: The first window begins when `en` is first seen high. After that a new window begins every `WIN_TICKS` cycles in which `tick` is high and `en` is high. When `tick` is held high, row 0 with rate bit 1 is accepted exactly `WIN_TICKS` cycles apart in consecutive windows.
- R3: Within a window, rows are offered in ascending address order, from 0 to `ROWS-1`. No row is offered more than once per window.
- R4: A row whose rate bit is 1 (fast) is refreshed in every window.
- R5: A window phase counter starts at 0 with the first window and advances by one, modulo `SLOW_MULT`, at the end of each window. A row whose rate bit is 0 (slow) is refreshed only in windows whose phase is 0.
- R6: Once `ref_valid` is high, it stays high with `ref_row` unchanged until a cycle in which `ref_ready` is high.
- R7: A pulse on `upg_valid` sets the rate bit of `upg_row` to 1. If the scheduler evaluates that same row in the same cycle, the upgrade takes precedence over the stored bit, and the row is refreshed in that window.
- R8: While `en` is high, a rate bit that is 1 never returns to 0, and writes on the bulk-load port have no effect.
- R9: While `en` is low, a bulk-load write stores `load_val` as the rate bit of `load_row`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Refresh enable; also blocks bulk loads when high |
| tick | input | 1 | Base time tick; `WIN_TICKS` ticks make one normal window |
| load_we | input | 1 | Bulk-load write strobe |
| load_row | input | RW | Bulk-load row address |
| load_val | input | 1 | Bulk-load rate bit (1 = fast, 0 = slow) |
| upg_valid | input | 1 | Upgrade request strobe |
| upg_row | input | RW | Row to move to the fast rate |
| ref_valid | output | 1 | Refresh command valid |
| ref_row | output | RW | Row address of the refresh command |
| ref_ready | input | 1 | DRAM model accepts the refresh command |

## Verification
The hardest case to reach is an upgrade that arrives in the exact cycle in which the scheduler evaluates the upgraded slow row, in a window whose phase is not 0. The bench holds `ref_ready` low so that the scheduler stalls on the fast row just before the target row. It releases `ref_ready` and then pulses `upg_valid` for the target row in the next cycle, when that row is being evaluated. The scoreboard then expects the row to appear in that window and in every later window.

// File: rtl/rs_pkg.sv
package rs_pkg;
    typedef enum logic [1:0] {
        WALK_IDLE = 2'd0,
        WALK_EVAL = 2'd1,
        WALK_ISSUE = 2'd2
    } walk_st_e;
endpackage

// File: rtl/rs_rate_table.sv
module rs_rate_table #(
    parameter int ROWS = 64,
    parameter int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          load_we,
    input  logic [RW-1:0] load_row,
    input  logic          load_val,
    input  logic          upg_valid,
    input  logic [RW-1:0] upg_row,
    input  logic [RW-1:0] rd_row,
    output logic          rd_fast
);
    typedef struct packed {
        logic [ROWS-1:0] bits;
    } tbl_t;

    tbl_t tbl_d, tbl_q;
    logic [ROWS-1:0] upg_hit;

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < ROWS; i++) begin
            upg_hit[i] = upg_valid && (upg_row == RW'(i));
            if (!en && load_we && (load_row == RW'(i)))
                tbl_d.bits[i] = load_val;
            if (upg_hit[i])
                tbl_d.bits[i] = 1'b1;
        end
    end

    always_comb begin
        rd_fast = 1'b0;
        for (int i = 0; i < ROWS; i++)
            if (rd_row == RW'(i))
                rd_fast = tbl_q.bits[i] | upg_hit[i];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tbl_q <= '0;
        else        tbl_q <= tbl_d;
    end

    for (genvar g = 0; g < ROWS; g++) begin : g_bit_chk
        // R8
        no_downgrade_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (en && tbl_q.bits[g]) |=> tbl_q.bits[g]);
        // R7
        upgrade_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (upg_valid && upg_row == RW'(g)) |=> tbl_q.bits[g]);
    end
endmodule

// File: rtl/rs_win_timer.sv
module rs_win_timer #(
    parameter int WIN_TICKS = 64000,
    parameter int CW = (WIN_TICKS > 1) ? $clog2(WIN_TICKS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic tick,
    input  logic take,
    output logic due
);
    localparam logic [CW-1:0] LAST = CW'(WIN_TICKS - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          due;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic wrap;

    always_comb begin
        tmr_d = tmr_q;
        wrap  = 1'b0;
        if (en && tick) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.cnt = '0;
                wrap      = 1'b1;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
        tmr_d.due = (tmr_q.due && !take) || wrap;
    end

    assign due = tmr_q.due;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tmr_q.cnt <= '0;
            tmr_q.due <= 1'b1;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    // R2
    cnt_in_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tmr_q.cnt <= LAST);
endmodule

// File: rtl/rs_walker.sv
module rs_walker #(
    parameter int ROWS = 64,
    parameter int SLOW_MULT = 4,
    parameter int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    parameter int PW = (SLOW_MULT > 1) ? $clog2(SLOW_MULT) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          due,
    input  logic          rd_fast,
    input  logic          ref_ready,
    output logic          take,
    output logic [RW-1:0] rd_row,
    output logic          ref_valid,
    output logic [RW-1:0] ref_row
);
    import rs_pkg::*;

    localparam logic [RW-1:0] LAST_ROW = RW'(ROWS - 1);
    localparam logic [PW-1:0] LAST_PH  = PW'(SLOW_MULT - 1);

    typedef struct packed {
        walk_st_e      st;
        logic [RW-1:0] row;
        logic [PW-1:0] phase;
    } walk_t;

    walk_t w_d, w_q;
    logic  need;
    logic [PW-1:0] phase_nx;

    always_comb begin
        w_d      = w_q;
        take     = 1'b0;
        need     = rd_fast || (w_q.phase == '0);
        phase_nx = (w_q.phase == LAST_PH) ? '0 : w_q.phase + 1'b1;
        unique case (w_q.st)
            WALK_IDLE: begin
                if (en && due) begin
                    take    = 1'b1;
                    w_d.st  = WALK_EVAL;
                    w_d.row = '0;
                end
            end
            WALK_EVAL: begin
                if (need) begin
                    w_d.st = WALK_ISSUE;
                end else if (w_q.row == LAST_ROW) begin
                    w_d.st    = WALK_IDLE;
                    w_d.phase = phase_nx;
                end else begin
                    w_d.row = w_q.row + 1'b1;
                end
            end
            WALK_ISSUE: begin
                if (ref_ready) begin
                    if (w_q.row == LAST_ROW) begin
                        w_d.st    = WALK_IDLE;
                        w_d.phase = phase_nx;
                    end else begin
                        w_d.st  = WALK_EVAL;
                        w_d.row = w_q.row + 1'b1;
                    end
                end
            end
            default: w_d.st = WALK_IDLE;
        endcase
    end

    assign rd_row    = w_q.row;
    assign ref_valid = (w_q.st == WALK_ISSUE);
    assign ref_row   = w_q.row;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            w_q.st    <= WALK_IDLE;
            w_q.row   <= '0;
            w_q.phase <= '0;
        end else begin
            w_q <= w_d;
        end
    end

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && !ref_ready) |=> (ref_valid && $stable(ref_row)));
    // R3
    row_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ref_valid |-> ({1'b0, ref_row} <= {1'b0, LAST_ROW}));
    // R3
    row_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ref_valid && ref_ready && ref_row != LAST_ROW) |=> (w_q.row == $past(ref_row) + 1'b1));
    // R5
    slow_only_phase0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (w_q.st == WALK_EVAL && w_q.phase != '0 && !rd_fast) |=> !ref_valid);
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched #(
    parameter int ROWS = 64,
    parameter int WIN_TICKS = 64000,
    parameter int SLOW_MULT = 4,
    parameter int RW = (ROWS > 1) ? $clog2(ROWS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tick,
    input  logic          load_we,
    input  logic [RW-1:0] load_row,
    input  logic          load_val,
    input  logic          upg_valid,
    input  logic [RW-1:0] upg_row,
    output logic          ref_valid,
    output logic [RW-1:0] ref_row,
    input  logic          ref_ready
);
    logic          due;
    logic          take;
    logic          rd_fast;
    logic [RW-1:0] rd_row;

    rs_win_timer #(.WIN_TICKS(WIN_TICKS)) u_timer (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .take(take), .due(due)
    );

    rs_rate_table #(.ROWS(ROWS), .RW(RW)) u_table (
        .clk(clk), .rst_n(rst_n), .en(en),
        .load_we(load_we), .load_row(load_row), .load_val(load_val),
        .upg_valid(upg_valid), .upg_row(upg_row),
        .rd_row(rd_row), .rd_fast(rd_fast)
    );

    rs_walker #(.ROWS(ROWS), .SLOW_MULT(SLOW_MULT), .RW(RW)) u_walk (
        .clk(clk), .rst_n(rst_n), .en(en), .due(due), .rd_fast(rd_fast),
        .ref_ready(ref_ready), .take(take), .rd_row(rd_row),
        .ref_valid(ref_valid), .ref_row(ref_row)
    );
endmodule

// File: tb/sim_refresh_sched.sv
module sim_refresh_sched;
    localparam int ROWS = 8;
    localparam int WIN  = 40;
    localparam int SLOW = 4;
    localparam int RW   = 3;

    logic clk = 1'b0;
    logic rst_n, en, tick, load_we, load_val, upg_valid, ref_valid, ref_ready;
    logic [RW-1:0] load_row, upg_row, ref_row;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int q[$];
    bit exp_tbl[ROWS];
    int last0 = 0;
    int n0 = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    refresh_sched #(.ROWS(ROWS), .WIN_TICKS(WIN), .SLOW_MULT(SLOW)) u0 (
        .clk(clk), .rst_n(rst_n), .en(en), .tick(tick),
        .load_we(load_we), .load_row(load_row), .load_val(load_val),
        .upg_valid(upg_valid), .upg_row(upg_row),
        .ref_valid(ref_valid), .ref_row(ref_row), .ref_ready(ref_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // R4, R5: expected refresh order of one window
    task automatic push_window(input int w);
        for (int r = 0; r < ROWS; r++)
            if (exp_tbl[r] || (w % SLOW) == 0) q.push_back(r);
    endtask

    task automatic drain();
        while (q.size() != 0) @(negedge clk);
    endtask

    // monitor: compares each accepted refresh with the scoreboard (R3, R4, R5)
    always @(negedge clk) begin
        if (rst_n && ref_valid && ref_ready) begin
            if (q.size() == 0) begin
                check(1'b0, "R3/R5 unexpected refresh", int'(ref_row), -1);
            end else begin
                int e;
                e = q.pop_front();
                check(int'(ref_row) == e, "R3/R4/R5 refresh order", int'(ref_row), e);
            end
            if (ref_row == 0) begin
                if (n0 >= 1 && n0 <= 8)
                    check(cyc - last0 == WIN, "R2 window period", cyc - last0, WIN);
                last0 = cyc;
                n0++;
            end
        end
    end

    initial begin
        #(8 * 200000);
        check(1'b0, "watchdog", 0, 1);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b0; tick = 1'b1; load_we = 1'b0; load_row = '0;
        load_val = 1'b0; upg_valid = 1'b0; upg_row = '0; ref_ready = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check(ref_valid == 1'b0, "R1 idle after reset", int'(ref_valid), 0);
        end
        // R9: load profile rows 0, 2 and 7 fast
        for (int r = 0; r < ROWS; r++) begin
            exp_tbl[r] = (r == 0 || r == 2 || r == 7);
            @(posedge clk); #1;
            load_we = 1'b1; load_row = RW'(r); load_val = exp_tbl[r];
        end
        @(posedge clk); #1 load_we = 1'b0;
        repeat (4) @(negedge clk);
        check(ref_valid == 1'b0, "R1 idle while disabled", int'(ref_valid), 0);

        for (int w = 0; w < 8; w++) push_window(w);
        @(posedge clk); #1 en = 1'b1;
        // R8: loads while enabled have no effect
        repeat (5) @(posedge clk);
        #1 load_we = 1'b1; load_row = 3'd3; load_val = 1'b1;
        @(posedge clk); #1 load_row = 3'd0; load_val = 1'b0;
        @(posedge clk); #1 load_we = 1'b0;
        drain();
        push_window(8);
        drain();

        // stall on row 0 of window 9, then upgrade row 1 as it is evaluated (R6, R7)
        @(posedge clk); #1 ref_ready = 1'b0;
        exp_tbl[1] = 1'b1;
        for (int w = 9; w < 12; w++) push_window(w);
        @(negedge clk);
        while (!ref_valid) @(negedge clk);
        check(ref_row == 3'd0, "R6 stalled row", int'(ref_row), 0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            check(ref_valid && ref_row == 3'd0, "R6 hold while not ready", int'(ref_row), 0);
        end
        @(posedge clk); #1 ref_ready = 1'b1;
        @(posedge clk); #1 upg_valid = 1'b1; upg_row = 3'd1;
        @(posedge clk); #1 upg_valid = 1'b0;
        drain();
        @(posedge clk); #1 en = 1'b0;
        repeat (3 * WIN) @(negedge clk);
        check(q.size() == 0, "R7 scoreboard empty", q.size(), 0);
        check(n0 == 12, "R4 row 0 every window", n0, 12);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule